// File: doc/BRIEF.md
# Write-Back Cache Coherence Controller (Modified / Shared / Invalid)

This block keeps a small direct-mapped write-back cache coherent with the other caches on a shared snooping bus. Each line holds a tag, a data byte and one of three coherence states: Invalid, Shared (clean, possibly copied elsewhere) or Modified (dirty, the only valid copy). A local processor issues reads and writes through a request/done handshake. A request that needs the bus raises a bus request and waits for a grant. The block also watches every transaction that other caches put on the bus. When such a transaction touches a line it holds, the block supplies that line's data or drops its copy.

The address splits into an upper tag and a lower line index. On a grant the bus delivers the fill data, and the line is written in that same cycle. Snoop responses are combinational: the flush data appears in the same cycle as the snooped command, so memory and the requester can both capture it.

The request machine has four named states. IDLE looks up the line. WRITEBACK holds a write-back request for a dirty victim. ACQUIRE holds a read or read-to-own request. RESPOND pulses done for one cycle. The transitions are:
- IDLE goes to RESPOND on a hit.
- IDLE goes to WRITEBACK on a miss whose victim is dirty, and to ACQUIRE on any other miss.
- WRITEBACK goes to ACQUIRE on a grant, or back to IDLE if a snoop takes the victim first.
- ACQUIRE goes to RESPOND on a grant.
- RESPOND always returns to IDLE.

Top module: `msi_cache_ctrl`

## Requirements
- R1: A read whose line is Invalid or holds another tag raises a bus request with command 1 (read shared) and the full request address. On the grant, the line takes the bus data in state Shared, and done returns that data one cycle later.
- R2: A write to a line that is Invalid, or Shared with a matching tag, issues command 2 (read-to-own). On the grant, the line takes the write data in state Modified.
- R3: A read that hits a Shared or Modified line, and a write that hits a Modified line, raise no bus request. Done is high in the cycle after the request is accepted, and a read returns the stored byte.
- R4: A foreign command 1 that hits a Modified line drives flush_valid with that line's data in the same cycle, and the line becomes Shared.
- R5: A foreign command 2 that hits a Modified line flushes the line's data and leaves the line Invalid. A foreign command 2 that hits a Shared line invalidates it with no flush.
- R6: A foreign command 1 that hits a Shared line causes no flush, and the line stays Shared.
- R7: A miss whose victim line is Modified with another tag first issues command 3 (write-back), carrying the victim address {victim tag, index} and the victim data. After that grant, the miss command follows.
- R8: A raised bus request holds its command and address until the grant. The command reads 0 whenever no request is raised.
- R9: Snoops flagged as this cache's own transactions never flush and never change a line.
- R10: When a foreign snoop hits the line that an IDLE processor request maps to in the same cycle, the snoop is applied first. The lookup waits one cycle and then sees the new state.
- R11: After reset, every line is Invalid, and no request, done or flush is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | Processor request, held until done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 8 | Request address: tag in [7:2], index in [1:0] |
| cpu_wdata | input | 8 | Write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 8 | Read data, valid with done |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_cmd | output | 2 | 0 none, 1 read shared, 2 read-to-own, 3 write-back |
| bus_addr | output | 8 | Address of the requested transaction |
| bus_wdata | output | 8 | Write-back data |
| bus_rdata | input | 8 | Fill data, valid with the grant |
| snp_cmd | input | 2 | Snooped bus command, same encoding |
| snp_addr | input | 8 | Snooped address |
| snp_own | input | 1 | Snooped transaction was issued by this cache |
| flush_valid | output | 1 | Line data is driven for a snoop |
| flush_data | output | 8 | Flushed line data |

## Verification
The assertions assume a few things about the inputs. A processor request and its address stay stable from the moment it is raised until done. The arbiter never grants this cache in a cycle in which a foreign transaction is being snooped. No foreign transaction hits a line that another cache holds dirty in a conflicting way. The stimulus drives one operation at a time and one snoop at a time, and it keeps grants and foreign snoops in separate cycles. The single exception is the R10 case, where a processor lookup and a foreign snoop deliberately coincide.

// File: rtl/msi_cache_pkg.sv
package msi_cache_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_SHR = 2'd1,
        LN_MOD = 2'd2
    } line_state_t;

    typedef enum logic [1:0] {
        FSM_IDLE,
        FSM_WRITEBACK,
        FSM_ACQUIRE,
        FSM_RESPOND
    } req_state_t;

    localparam logic [1:0] CMD_NONE = 2'd0;
    localparam logic [1:0] CMD_RD   = 2'd1;
    localparam logic [1:0] CMD_RDX  = 2'd2;
    localparam logic [1:0] CMD_WB   = 2'd3;

endpackage

// File: rtl/msi_line_store.sv
module msi_line_store
    import msi_cache_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  cpu_idx,
    output line_state_t       cpu_st,
    output logic [TAG_W-1:0]  cpu_tag,
    output logic [DATA_W-1:0] cpu_data,
    input  logic [IDX_W-1:0]  snp_idx,
    output line_state_t       snp_st,
    output logic [TAG_W-1:0]  snp_tag,
    output logic [DATA_W-1:0] snp_data,
    input  logic              snp_upd_en,
    input  line_state_t       snp_upd_st,
    input  logic              loc_en,
    input  logic [TAG_W-1:0]  loc_tag,
    input  line_state_t       loc_st,
    input  logic              loc_data_en,
    input  logic [DATA_W-1:0] loc_data
);

    line_state_t       st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[i]   <= LN_INV;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else if (snp_upd_en && snp_idx == IDX_W'(i)) begin
                st_q[i] <= snp_upd_st;
            end else if (loc_en && cpu_idx == IDX_W'(i)) begin
                st_q[i]  <= loc_st;
                tag_q[i] <= loc_tag;
                if (loc_data_en) begin
                    data_q[i] <= loc_data;
                end
            end
        end
    end

    assign cpu_st   = st_q[cpu_idx];
    assign cpu_tag  = tag_q[cpu_idx];
    assign cpu_data = data_q[cpu_idx];
    assign snp_st   = st_q[snp_idx];
    assign snp_tag  = tag_q[snp_idx];
    assign snp_data = data_q[snp_idx];

endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
    import msi_cache_pkg::*;
#(
    parameter int TAG_W = 6
) (
    input  logic [1:0]       snp_cmd,
    input  logic [TAG_W-1:0] snp_tag,
    input  logic             snp_own,
    input  line_state_t      line_st,
    input  logic [TAG_W-1:0] line_tag,
    output logic             snp_hit,
    output logic             upd_en,
    output line_state_t      upd_st,
    output logic             flush
);

    logic is_rd;
    logic is_rdx;

    always_comb begin
        is_rd   = (snp_cmd == CMD_RD);
        is_rdx  = (snp_cmd == CMD_RDX);
        snp_hit = !snp_own && (is_rd || is_rdx) &&
                  (line_st != LN_INV) && (line_tag == snp_tag);
        flush   = snp_hit && (line_st == LN_MOD);
        upd_en  = snp_hit && (is_rdx || line_st == LN_MOD);
        upd_st  = is_rdx ? LN_INV : LN_SHR;
    end

endmodule

// File: rtl/msi_req_fsm.sv
module msi_req_fsm
    import msi_cache_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int IDX_W  = 2,
    parameter int DATA_W = 8,
    localparam int ADDR_W = TAG_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  line_state_t       line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    input  logic              snoop_touch,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              loc_en,
    output logic [TAG_W-1:0]  loc_tag,
    output line_state_t       loc_st,
    output logic              loc_data_en,
    output logic [DATA_W-1:0] loc_data
);

    req_state_t        state_q, state_d;
    logic [DATA_W-1:0] rdata_q;
    logic              tag_hit, hit_path, victim_dirty, accept;

    always_comb begin
        tag_hit      = (line_st != LN_INV) && (line_tag == cpu_tag);
        hit_path     = tag_hit && (!cpu_we || line_st == LN_MOD);
        victim_dirty = (line_st == LN_MOD) && !tag_hit;
        accept       = cpu_req && !snoop_touch;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FSM_IDLE;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FSM_IDLE && accept && hit_path && !cpu_we) begin
                rdata_q <= line_data;
            end else if (state_q == FSM_ACQUIRE && bus_gnt) begin
                rdata_q <= cpu_we ? cpu_wdata : bus_rdata;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: begin
                if (accept) begin
                    if (hit_path)          state_d = FSM_RESPOND;
                    else if (victim_dirty) state_d = FSM_WRITEBACK;
                    else                   state_d = FSM_ACQUIRE;
                end
            end
            FSM_WRITEBACK: begin
                if (snoop_touch)  state_d = FSM_IDLE;
                else if (bus_gnt) state_d = FSM_ACQUIRE;
            end
            FSM_ACQUIRE: begin
                if (bus_gnt) state_d = FSM_RESPOND;
            end
            FSM_RESPOND: state_d = FSM_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpu_done    = 1'b0;
        cpu_rdata   = rdata_q;
        bus_req     = 1'b0;
        bus_cmd     = CMD_NONE;
        bus_addr    = '0;
        bus_wdata   = '0;
        loc_en      = 1'b0;
        loc_tag     = cpu_tag;
        loc_st      = LN_INV;
        loc_data_en = 1'b0;
        loc_data    = cpu_wdata;
        unique case (state_q)
            FSM_IDLE: begin
                if (accept && hit_path && cpu_we) begin
                    loc_en      = 1'b1;
                    loc_st      = LN_MOD;
                    loc_data_en = 1'b1;
                end
            end
            FSM_WRITEBACK: begin
                bus_req   = 1'b1;
                bus_cmd   = CMD_WB;
                bus_addr  = {line_tag, cpu_idx};
                bus_wdata = line_data;
                if (bus_gnt && !snoop_touch) begin
                    loc_en  = 1'b1;
                    loc_tag = line_tag;
                    loc_st  = LN_INV;
                end
            end
            FSM_ACQUIRE: begin
                bus_req  = 1'b1;
                bus_cmd  = cpu_we ? CMD_RDX : CMD_RD;
                bus_addr = {cpu_tag, cpu_idx};
                if (bus_gnt) begin
                    loc_en      = 1'b1;
                    loc_st      = cpu_we ? LN_MOD : LN_SHR;
                    loc_data_en = 1'b1;
                    loc_data    = cpu_we ? cpu_wdata : bus_rdata;
                end
            end
            FSM_RESPOND: cpu_done = 1'b1;
        endcase
    end

endmodule

// File: rtl/msi_cache_ctrl.sv
module msi_cache_ctrl
    import msi_cache_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic              snp_own,
    output logic              flush_valid,
    output logic [DATA_W-1:0] flush_data
);

    line_state_t       cpu_st, snp_st, snp_upd_st, loc_st;
    logic [TAG_W-1:0]  cpu_line_tag, snp_line_tag, loc_tag;
    logic [DATA_W-1:0] cpu_line_data, snp_line_data, loc_data;
    logic              snp_hit, snp_upd_en, snp_flush, loc_en, loc_data_en;
    logic              snoop_touch;

    msi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk, .rst_n,
        .cpu_idx     (cpu_addr[IDX_W-1:0]),
        .cpu_st      (cpu_st),
        .cpu_tag     (cpu_line_tag),
        .cpu_data    (cpu_line_data),
        .snp_idx     (snp_addr[IDX_W-1:0]),
        .snp_st      (snp_st),
        .snp_tag     (snp_line_tag),
        .snp_data    (snp_line_data),
        .snp_upd_en  (snp_upd_en),
        .snp_upd_st  (snp_upd_st),
        .loc_en      (loc_en),
        .loc_tag     (loc_tag),
        .loc_st      (loc_st),
        .loc_data_en (loc_data_en),
        .loc_data    (loc_data)
    );

    msi_snoop_unit #(.TAG_W(TAG_W)) u_snoop (
        .snp_cmd  (snp_cmd),
        .snp_tag  (snp_addr[ADDR_W-1:IDX_W]),
        .snp_own  (snp_own),
        .line_st  (snp_st),
        .line_tag (snp_line_tag),
        .snp_hit  (snp_hit),
        .upd_en   (snp_upd_en),
        .upd_st   (snp_upd_st),
        .flush    (snp_flush)
    );

    assign snoop_touch = snp_hit && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
    assign flush_valid = snp_flush;
    assign flush_data  = snp_flush ? snp_line_data : '0;

    msi_req_fsm #(.TAG_W(TAG_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
        .clk, .rst_n,
        .cpu_req     (cpu_req),
        .cpu_we      (cpu_we),
        .cpu_tag     (cpu_addr[ADDR_W-1:IDX_W]),
        .cpu_idx     (cpu_addr[IDX_W-1:0]),
        .cpu_wdata   (cpu_wdata),
        .line_st     (cpu_st),
        .line_tag    (cpu_line_tag),
        .line_data   (cpu_line_data),
        .snoop_touch (snoop_touch),
        .bus_gnt     (bus_gnt),
        .bus_rdata   (bus_rdata),
        .cpu_done    (cpu_done),
        .cpu_rdata   (cpu_rdata),
        .bus_req     (bus_req),
        .bus_cmd     (bus_cmd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .loc_en      (loc_en),
        .loc_tag     (loc_tag),
        .loc_st      (loc_st),
        .loc_data_en (loc_data_en),
        .loc_data    (loc_data)
    );

endmodule

// File: rtl/msi_cache_chk.sv
module msi_cache_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic              bus_gnt,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [1:0]        snp_cmd,
    input logic              snp_own,
    input logic              flush_valid
);

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_gnt && bus_cmd != 2'd3) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    // R8
    idle_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_cmd == 2'd0));

    // R9
    own_no_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_valid |-> (!snp_own && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

    // R7
    wb_then_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_gnt && bus_cmd == 2'd3) |=> (bus_req && bus_cmd != 2'd3 && bus_cmd != 2'd0));

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

endmodule

bind msi_cache_ctrl msi_cache_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_done    (cpu_done),
    .bus_req     (bus_req),
    .bus_gnt     (bus_gnt),
    .bus_cmd     (bus_cmd),
    .bus_addr    (bus_addr),
    .snp_cmd     (snp_cmd),
    .snp_own     (snp_own),
    .flush_valid (flush_valid)
);

// File: tb/msi_cache_ctrl_tb.sv
`timescale 1ns/1ps
module msi_cache_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0;
    logic       cpu_done;
    logic [7:0] cpu_rdata;
    logic       bus_req;
    logic       bus_gnt = 1'b0;
    logic [1:0] bus_cmd;
    logic [7:0] bus_addr, bus_wdata;
    logic [7:0] bus_rdata = '0;
    logic [1:0] snp_cmd = '0;
    logic [7:0] snp_addr = '0;
    logic       snp_own = 1'b0;
    logic       flush_valid;
    logic [7:0] flush_data;

    int nchk = 0;
    int nfail = 0;

    // reference model: 0 invalid, 1 shared, 2 modified
    int         mst  [4];
    logic [5:0] mtag [4];
    logic [7:0] mdat [4];

    always #5 clk = ~clk;

    msi_cache_ctrl u_dut (
        .clk, .rst_n, .cpu_req, .cpu_we, .cpu_addr, .cpu_wdata, .cpu_done, .cpu_rdata,
        .bus_req, .bus_gnt, .bus_cmd, .bus_addr, .bus_wdata, .bus_rdata,
        .snp_cmd, .snp_addr, .snp_own, .flush_valid, .flush_data
    );

    task automatic chk(input string rq, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
        end
    endtask

    // per-clock comparison of the idle bus command (R8)
    always @(negedge clk) begin
        #3;
        if (rst_n && !bus_req) chk("R8 idle cmd", bus_cmd, 0);
    end

    task automatic do_op(input bit we, input logic [7:0] a, input logic [7:0] wd,
                         input logic [7:0] fill, input string rq);
        int ix;
        logic [5:0] tg;
        bit thit, hitp, wb;
        ix   = int'(a[1:0]);
        tg   = a[7:2];
        thit = (mst[ix] != 0) && (mtag[ix] == tg);
        hitp = thit && (!we || mst[ix] == 2);
        wb   = !thit && (mst[ix] == 2);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        @(negedge clk); #1;
        if (hitp) begin
            chk({rq, " no bus"}, bus_req, 0);
            chk({rq, " done"}, cpu_done, 1);
            if (!we) chk({rq, " rdata"}, cpu_rdata, mdat[ix]);
            if (we) mdat[ix] = wd;
        end else begin
            if (wb) begin
                chk("R7 wb cmd", bus_cmd, 3);
                chk("R7 wb addr", bus_addr, {mtag[ix], a[1:0]});
                chk("R7 wb data", bus_wdata, mdat[ix]);
                @(negedge clk); #1;
                chk("R8 wb held", bus_req, 1);
                chk("R8 wb cmd held", bus_cmd, 3);
                bus_gnt = 1'b1;
                @(negedge clk); bus_gnt = 1'b0; #1;
                chk("R7 miss follows", bus_cmd, we ? 2 : 1);
                mst[ix] = 0;
            end
            chk({rq, " req"}, bus_req, 1);
            chk({rq, " cmd"}, bus_cmd, we ? 2 : 1);
            chk({rq, " addr"}, bus_addr, a);
            @(negedge clk); #1;
            chk("R8 held", bus_req, 1);
            chk("R8 addr held", bus_addr, a);
            bus_gnt = 1'b1; bus_rdata = fill;
            @(negedge clk); bus_gnt = 1'b0; #1;
            chk({rq, " done"}, cpu_done, 1);
            if (!we) chk({rq, " rdata"}, cpu_rdata, fill);
            mtag[ix] = tg;
            mst[ix]  = we ? 2 : 1;
            mdat[ix] = we ? wd : fill;
        end
        cpu_req = 1'b0;
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input bit own, input string rq);
        int ix;
        bit hit, fl;
        ix  = int'(a[1:0]);
        hit = !own && (c == 1 || c == 2) && mst[ix] != 0 && mtag[ix] == a[7:2];
        fl  = hit && mst[ix] == 2;
        @(negedge clk);
        snp_cmd = c; snp_addr = a; snp_own = own; #1;
        chk({rq, " flush"}, flush_valid, fl);
        if (fl) chk({rq, " flush data"}, flush_data, mdat[ix]);
        if (hit) mst[ix] = (c == 2) ? 0 : 1;
        @(negedge clk);
        snp_cmd = '0; snp_own = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin mst[i] = 0; mtag[i] = '0; mdat[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R11 req", bus_req, 0);
        chk("R11 done", cpu_done, 0);
        chk("R11 flush", flush_valid, 0);
        do_op(0, 8'h00, 8'h00, 8'h5A, "R11 tag0 invalid");

        do_op(0, 8'h05, 8'h00, 8'hA5, "R1 read miss");
        do_op(0, 8'h05, 8'h00, 8'h00, "R3 read hit S");
        do_op(1, 8'h05, 8'h3C, 8'hEE, "R2 upgrade S");
        do_op(1, 8'h05, 8'h3D, 8'h00, "R3 write hit M");
        do_op(0, 8'h05, 8'h00, 8'h00, "R3 read hit M");
        snoop(2'd1, 8'h05, 0, "R4 rd on M");
        snoop(2'd1, 8'h05, 0, "R6 rd on S");
        do_op(0, 8'h05, 8'h00, 8'h00, "R6 still S");
        do_op(1, 8'h05, 8'h41, 8'h00, "R4 now S needs RdX");
        snoop(2'd1, 8'h05, 0, "R4 second");

        do_op(1, 8'h06, 8'h11, 8'hEE, "R2 write miss I");
        snoop(2'd2, 8'h06, 0, "R5 rdx on M");
        do_op(0, 8'h06, 8'h00, 8'h22, "R5 refetch after M inval");
        snoop(2'd2, 8'h05, 0, "R5 rdx on S");
        do_op(0, 8'h05, 8'h00, 8'h44, "R5 refetch after S inval");

        do_op(1, 8'h07, 8'h55, 8'h00, "R2 write miss");
        snoop(2'd2, 8'h07, 1, "R9 own rdx");
        snoop(2'd1, 8'h07, 1, "R9 own rd");
        do_op(0, 8'h07, 8'h00, 8'h00, "R9 line kept");
        do_op(0, 8'h0B, 8'h00, 8'h66, "R7 dirty evict read");
        snoop(2'd2, 8'h03, 0, "R5 other tag miss");
        do_op(0, 8'h0B, 8'h00, 8'h00, "R3 hit after evict");

        // R10: processor write hit and foreign snoop on the same line together
        do_op(1, 8'h10, 8'h77, 8'h00, "R2 idx0");
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 8'h10; cpu_wdata = 8'h99;
        snp_cmd = 2'd2; snp_addr = 8'h10; snp_own = 1'b0; #1;
        chk("R10 flush old", flush_valid, 1);
        chk("R10 flush data", flush_data, 8'h77);
        @(negedge clk);
        snp_cmd = '0; #1;
        chk("R10 no done", cpu_done, 0);
        chk("R10 lookup waits", bus_req, 0);
        @(negedge clk); #1;
        chk("R10 sees invalid", bus_cmd, 2);
        bus_gnt = 1'b1;
        @(negedge clk); bus_gnt = 1'b0; #1;
        chk("R10 done", cpu_done, 1);
        cpu_req = 1'b0;
        mst[0] = 2; mtag[0] = 6'h04; mdat[0] = 8'h99;

        do_op(1, 8'h14, 8'h88, 8'hEE, "R7 dirty evict write");
        do_op(0, 8'h14, 8'h00, 8'h00, "R3 read back");

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule